// File: doc/BRIEF.md
# Serial Memory Page-Write Commit Sequencer

This block sits between the serial command front-end of a non-volatile memory model and its storage array. While a data-write command streams in, it gathers the incoming bytes into a one-page buffer. Bytes land at successive offsets inside the page, and a per-offset mask records which offsets were actually received. A status-write command instead keeps a single byte. The front-end reports each rising serial clock edge, each completed byte, the start address and the rising edge of chip select, all as single-cycle strobes in the system clock domain. A separate protect block supplies a permit level.

The buffered data is committed only if chip select rises in the short interval after the last bit of a byte has been taken and before the next rising serial clock edge. A rise at any other moment drops the command. Once the data is committed, the block raises a busy flag for a fixed, parameterised number of cycles that stands in for the programming time. It also emits a one-cycle pulse that clears the write-enable latch. During the first cycles of busy it replays the buffered bytes to the array in ascending offset order, one strobe per cycle, or it issues the single status-register strobe. No new command can start or cancel anything until busy falls.

Top module: `pwb_sequencer`

## Requirements
- R1: After reset, busy, mem_we, stat_we and wen_clr are all 0.
- R2: Bytes of a data write go to successive offsets (low 6 address bits) of the page given by load_page, with the upper address bits held fixed. After offset 63 the offset wraps to 0.
- R3: When more than 64 bytes are sent, a later byte replaces the earlier byte at the same offset. Each offset is written once per commit, with the newest data.
- R4: Only offsets that received a byte in the current command are written. load_page discards the mask of any earlier command.
- R5: A data write commits only if cs_rise comes after a byte_valid and before the next sck_rise. A cs_rise during the address phase, in mid-byte, or after an extra sck_rise cancels the command: busy stays 0 and nothing is written.
- R6: A status write commits only if cs_rise comes after its first data byte and before the next sck_rise. A second byte does not reopen the window.
- R7: If permit is 0 in the cycle of cs_rise, the command is cancelled.
- R8: On a commit, busy rises in the cycle after cs_rise and stays high for exactly BUSY_CYCLES cycles. While busy is high, load_page, load_stat, byte_valid, sck_rise and cs_rise have no effect.
- R9: wen_clr is a one-cycle pulse in the first busy cycle of each commit, and it never occurs otherwise.
- R10: During busy cycle k (k counted from 0, k below 64), mem_we is high exactly when offset k was received, with mem_addr = {page, k}. A status commit gives one stat_we with stat_data in busy cycle 0. mem_we and stat_we are high only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_page | input | 1 | Pulse: data-write address captured, new page command begins |
| page_addr | input | ADDR_W | Start byte address of the data write |
| load_stat | input | 1 | Pulse: status-write command begins |
| sck_rise | input | 1 | Pulse: a rising serial clock edge took a bit |
| byte_valid | input | 1 | Pulse with the edge that completed a byte |
| byte_data | input | 8 | The completed byte |
| cs_rise | input | 1 | Pulse: chip select went inactive |
| permit | input | 1 | Protect logic allows this write |
| busy | output | 1 | Programming in progress |
| wen_clr | output | 1 | Pulse clearing the write-enable latch |
| mem_we | output | 1 | Array byte write strobe |
| mem_addr | output | ADDR_W | Array byte address |
| mem_wdata | output | 8 | Array byte data |
| stat_we | output | 1 | Status register write strobe |
| stat_data | output | 8 | Status register write data |

## Verification
The bench targets the commit window from every side. It raises chip select mid-byte, during the address phase, one serial edge too late, and after a second status byte. A design that checked only the bit count, and not the following edge, would start programming on a late rise. It starts pages near their end to catch a carry leaking into the upper address bits, and it overruns a page to catch a design that writes stale bytes or writes an offset twice. It also chains a short command after a longer one, so that a mask that was not cleared shows up as extra array strobes. Finally, it fires full commands while busy is high, so that a design that accepted them would lengthen busy or emit extra strobes.

// File: rtl/pwb_sequencer.sv
module pwb_sequencer #(
  parameter int ADDR_W      = 14,
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_page,
  input  logic [ADDR_W-1:0] page_addr,
  input  logic              load_stat,
  input  logic              sck_rise,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              cs_rise,
  input  logic              permit,
  output logic              busy,
  output logic              wen_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              stat_we,
  output logic [7:0]        stat_data
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int HI_W  = ADDR_W - OFF_W;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [1:0] M_IDLE = 2'd0, M_PAGE = 2'd1, M_STAT = 2'd2;

  logic [1:0]            mode, kind;
  logic                  armed, stat_got;
  logic [HI_W-1:0]       hi;
  logic [OFF_W-1:0]      off;
  logic [PAGE_BYTES-1:0] vmask;
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [7:0]            sbyte;
  logic [CNT_W-1:0]      cnt;
  logic [OFF_W-1:0]      idx;

  wire take_page = !busy && mode == M_PAGE && byte_valid;
  wire take_stat = !busy && mode == M_STAT && byte_valid && !stat_got;
  wire commit    = !busy && cs_rise && armed && permit && mode != M_IDLE;

  assign idx       = cnt[OFF_W-1:0];
  assign mem_we    = busy && kind == M_PAGE && cnt < CNT_W'(PAGE_BYTES) && vmask[idx];
  assign mem_addr  = {hi, idx};
  assign mem_wdata = pbuf[idx];
  assign stat_we   = busy && kind == M_STAT && cnt == '0;
  assign stat_data = sbyte;
  assign wen_clr   = busy && cnt == '0;

  always_ff @(posedge clk) begin
    if (take_page) pbuf[off] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_IDLE;
      kind     <= M_IDLE;
      armed    <= 1'b0;
      stat_got <= 1'b0;
      hi       <= '0;
      off      <= '0;
      vmask    <= '0;
      sbyte    <= '0;
      busy     <= 1'b0;
      cnt      <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(BUSY_CYCLES - 1)) busy <= 1'b0;
    end else if (cs_rise) begin
      mode  <= M_IDLE;
      armed <= 1'b0;
      if (commit) begin
        busy <= 1'b1;
        kind <= mode;
        cnt  <= '0;
      end
    end else if (load_page) begin
      mode  <= M_PAGE;
      hi    <= page_addr[ADDR_W-1:OFF_W];
      off   <= page_addr[OFF_W-1:0];
      vmask <= '0;
      armed <= 1'b0;
    end else if (load_stat) begin
      mode     <= M_STAT;
      stat_got <= 1'b0;
      armed    <= 1'b0;
    end else if (take_page) begin
      vmask[off] <= 1'b1;
      off        <= off + 1'b1;
      armed      <= 1'b1;
    end else if (take_stat) begin
      sbyte    <= byte_data;
      stat_got <= 1'b1;
      armed    <= 1'b1;
    end else if (sck_rise) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/pwb_sequencer_chk.sv
module pwb_sequencer_chk #(
  parameter int BUSY_CYCLES = 100
) (
  input logic clk,
  input logic rst_n,
  input logic cs_rise,
  input logic permit,
  input logic busy,
  input logic wen_clr,
  input logic mem_we,
  input logic stat_we
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 0;
    else        run_q <= busy ? run_q + 1 : 0;
  end

  a_r8_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_q < BUSY_CYCLES);
  a_r8_busy_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(run_q) == BUSY_CYCLES - 1);
  a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && permit));
  a_r9_wen_clr_start: assert property (@(posedge clk) disable iff (!rst_n)
    wen_clr |-> $rose(busy));
  a_r9_wen_clr_each: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen_clr);
  a_r10_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || stat_we) |-> busy);
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && stat_we));
endmodule

bind pwb_sequencer pwb_sequencer_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .permit(permit),
  .busy(busy), .wen_clr(wen_clr), .mem_we(mem_we), .stat_we(stat_we)
);

// File: tb/pwb_sequencer_tb.sv
module pwb_sequencer_tb;
  localparam int AW = 14;
  localparam int BC = 100;

  logic clk = 0, rst_n = 0;
  logic load_page = 0, load_stat = 0, sck_rise = 0, byte_valid = 0, cs_rise = 0, permit = 1;
  logic [AW-1:0] page_addr = '0;
  logic [7:0] byte_data = '0;
  logic busy, wen_clr, mem_we, stat_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, stat_data;

  always #10 clk = ~clk;

  pwb_sequencer #(.ADDR_W(AW), .PAGE_BYTES(64), .BUSY_CYCLES(BC)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_page(load_page), .page_addr(page_addr),
    .load_stat(load_stat), .sck_rise(sck_rise), .byte_valid(byte_valid),
    .byte_data(byte_data), .cs_rise(cs_rise), .permit(permit), .busy(busy),
    .wen_clr(wen_clr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .stat_we(stat_we), .stat_data(stat_data));

  int tests = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_mode = 0, m_kind = 0, m_t = 0, m_off = 0, m_hi = 0, m_chi = 0;
  bit m_armed = 0, m_got = 0, m_busy = 0;
  byte unsigned m_buf[64], m_cbuf[64], m_sb = 0, m_csb = 0;
  bit m_val[64], m_cval[64];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_armed = 0; m_busy = 0; m_t = 0;
    end else if (m_busy) begin
      m_t++;
      if (m_t == BC) m_busy = 0;
    end else if (cs_rise) begin
      if (m_armed && permit && m_mode != 0) begin
        m_busy = 1; m_t = 0; m_kind = m_mode; m_chi = m_hi; m_csb = m_sb;
        m_cbuf = m_buf; m_cval = m_val;
      end
      m_mode = 0; m_armed = 0;
    end else if (load_page) begin
      m_mode = 1; m_hi = int'(page_addr) / 64; m_off = int'(page_addr) % 64;
      foreach (m_val[i]) m_val[i] = 0;
      m_armed = 0;
    end else if (load_stat) begin
      m_mode = 2; m_got = 0; m_armed = 0;
    end else if (byte_valid && m_mode == 1) begin
      m_buf[m_off] = byte_data; m_val[m_off] = 1; m_off = (m_off + 1) % 64; m_armed = 1;
    end else if (byte_valid && m_mode == 2 && !m_got) begin
      m_sb = byte_data; m_got = 1; m_armed = 1;
    end else if (sck_rise) begin
      m_armed = 0;
    end
  end

  // per-cycle comparison and write log
  int nwr = 0, nst = 0, nclr = 0;
  logic [AW-1:0] lg_a[128];
  logic [7:0] lg_d[128];
  logic [7:0] lst_d;

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_we;
      e_we = m_busy && m_kind == 1 && m_t < 64 && m_cval[m_t % 64];
      chk(busy == m_busy, "R8 busy", busy, m_busy);
      chk(wen_clr == (m_busy && m_t == 0), "R9 wen_clr", wen_clr, m_busy && m_t == 0);
      chk(mem_we == e_we, "R10 mem_we", mem_we, e_we);
      if (e_we) begin
        chk(int'(mem_addr) == m_chi * 64 + m_t, "R2 mem_addr", mem_addr, m_chi * 64 + m_t);
        chk(mem_wdata == m_cbuf[m_t], "R3 mem_wdata", mem_wdata, m_cbuf[m_t]);
      end
      chk(stat_we == (m_busy && m_kind == 2 && m_t == 0), "R10 stat_we", stat_we, 0);
      if (stat_we) chk(stat_data == m_csb, "R6 stat_data", stat_data, m_csb);
      if (mem_we && nwr < 128) begin lg_a[nwr] = mem_addr; lg_d[nwr] = mem_wdata; end
      if (mem_we) nwr++;
      if (stat_we) begin nst++; lst_d = stat_data; end
      if (wen_clr) nclr++;
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic edge_(input bit v, input logic [7:0] d);
    sck_rise = 1; byte_valid = v; byte_data = d; step();
    sck_rise = 0; byte_valid = 0; step();
  endtask
  task automatic send_byte(input logic [7:0] d);
    for (int i = 0; i < 7; i++) edge_(0, 8'h00);
    edge_(1, d);
  endtask
  task automatic bits(input int n);
    for (int i = 0; i < n; i++) edge_(0, 8'h00);
  endtask
  task automatic start_page(input int a);
    page_addr = AW'(a); load_page = 1; step(); load_page = 0; step();
  endtask
  task automatic start_stat();
    load_stat = 1; step(); load_stat = 0; step();
  endtask
  task automatic cs_up();
    cs_rise = 1; step(); cs_rise = 0; step();
  endtask
  task automatic settle();
    for (int i = 0; i < BC + 10; i++) step();
  endtask
  task automatic clr_log(); nwr = 0; nst = 0; nclr = 0; endtask

  initial begin
    repeat (3) step();
    chk(busy == 0 && mem_we == 0 && stat_we == 0 && wen_clr == 0, "R1 reset outputs", busy, 0);
    rst_n = 1; step();

    // R2 basic three-byte write
    clr_log(); bits(16); start_page(14'h0105);
    send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3); cs_up();
    settle();
    chk(nwr == 3, "R2 write count", nwr, 3);
    chk(lg_a[0] == 14'h0105 && lg_a[2] == 14'h0107, "R2 addresses", lg_a[2], 14'h0107);
    chk(nclr == 1, "R9 one wen_clr", nclr, 1);

    // R2/R4 wrap inside page, mask cleared from previous command
    clr_log(); start_page(14'h02FE);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); cs_up();
    settle();
    chk(nwr == 3, "R4 only received offsets", nwr, 3);
    chk(lg_a[0] == 14'h02C0 && lg_d[0] == 8'h33, "R2 wrap keeps page", lg_a[0], 14'h02C0);
    chk(lg_a[2] == 14'h02FF, "R2 last offset", lg_a[2], 14'h02FF);

    // R3 overrun: 66 bytes from offset 0
    clr_log(); start_page(14'h1000);
    for (int i = 0; i < 66; i++) send_byte(8'(i + 16));
    cs_up(); settle();
    chk(nwr == 64, "R3 one write per offset", nwr, 64);
    chk(lg_d[0] == 8'h50 && lg_d[1] == 8'h51, "R3 newest data kept", lg_d[0], 8'h50);
    chk(lg_d[2] == 8'h12, "R3 untouched offset", lg_d[2], 8'h12);

    // R5 cancel in mid-byte
    clr_log(); start_page(14'h0040); send_byte(8'h01); bits(4); cs_up();
    for (int i = 0; i < 5; i++) step();
    chk(busy == 0, "R5 mid-byte cancel busy", busy, 0);
    // R5 cancel after extra edge
    start_page(14'h0040); send_byte(8'h01); bits(1); cs_up(); settle();
    chk(nwr == 0 && nclr == 0, "R5 late rise cancels", nwr, 0);
    // R5 cancel during address phase
    bits(10); cs_up(); settle();
    chk(nclr == 0, "R5 address-phase rise", nclr, 0);

    // R7 no permit
    clr_log(); permit = 0; start_page(14'h0200); send_byte(8'h5A); cs_up(); permit = 1; settle();
    chk(nwr == 0 && nclr == 0, "R7 permit low cancels", nwr, 0);

    // R6 status write
    clr_log(); bits(8); start_stat(); send_byte(8'h8C); cs_up(); settle();
    chk(nst == 1 && lst_d == 8'h8C, "R6 status commit", lst_d, 8'h8C);
    chk(nwr == 0, "R10 no array write on status", nwr, 0);
    clr_log(); start_stat(); send_byte(8'h0C); send_byte(8'h04); cs_up(); settle();
    chk(nst == 0 && nclr == 0, "R6 second byte closes window", nst, 0);

    // R8 inputs ignored while busy
    clr_log(); start_page(14'h0300); send_byte(8'hE1); cs_up();
    start_page(14'h0310); send_byte(8'hE2); cs_up();
    start_stat(); send_byte(8'h80); cs_up();
    settle();
    chk(nwr == 1 && lg_d[0] == 8'hE1, "R8 busy ignores commands", nwr, 1);
    chk(nst == 0 && nclr == 1, "R8 no second commit", nclr, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule